// File: doc/BRIEF.md
# Time-Slot Interchange Output Path

This block builds the four serial output streams of a time-slot interchange. Each stream carries 32 byte-wide channels per frame, one bit per bit cell, with the most significant bit first. For every output channel the block reads two connection entries. The first is a per-channel control byte. The second is a byte that serves either as a source address or as the literal byte to send. From these it picks the outgoing byte. The byte is either a switched sample fetched from the data memory, or a repeated host message that is sent as stored. The block also produces a per-stream drive enable for an external tri-state buffer.

A free-running timing generator supplies the channel and bit counters. The connection memory and the data memory sit outside the block, and each is read through one synchronous port with one cycle of latency. The ports are shared across the four streams by a fixed schedule. The entries for channel c+1 are fetched while channel c is being shifted out. Everything is therefore ready when the channel boundary arrives. The streams run at a fixed rate and take no back-pressure. The memory read ports have no valid/ready handshake, because every read is issued in a known bit slot and its data is used exactly one cycle later.

Top module: `tsi_out_path`

## Requirements
- R1: While `rst_n` is low, every `st_oe` bit and every `st_out` bit is 0. After reset is released they stay 0 until the first channel boundary.
- R2: In a switched channel, the data-memory address is bits 6..0 of the low entry. Bits 6..5 give the source stream and bits 4..0 give the source channel, so the address is stream*32+channel. The byte read from that address is transmitted. Bit 7 of the low entry plays no part in the address.
- R3: When bit 2 of the control entry is 1, all 8 bits of the low entry, bit 7 included, are transmitted in that channel.
- R4: A message byte is sent again in every frame for as long as its low entry is unchanged. A new low entry takes effect in the frame after it is written.
- R5: When `msg_all` is 1, every channel of every stream sends its low entry and is driven. This holds whatever bits 2 and 0 of its control entry are.
- R6: When `ode` is 0, every `st_oe` bit is 0 within the same cycle, overriding all other settings.
- R7: When `ode` is 1 and `msg_all` is 0, bit 0 of the control entry sets `st_oe` for the whole channel (1 = drive, 0 = high impedance).
- R8: Bit 1 and bits 7..3 of the control entry have no effect on data or enable.
- R9: During bit cell k (`bit_cnt` = k, 0..7) of channel c, `st_out[s]` carries bit 7-k of the byte chosen for stream s, channel c.
- R10: With `ode` held steady, `st_oe` changes only at the first bit cell of a channel.
- R11: During bit cell b < 4, `cm_addr` is {b, c+1}, with the stream in bits 6..5 and the channel in bits 4..0. During bit cell b in 1..4, `dm_addr` equals bits 6..0 of the low entry returned for stream b-1.
- R12: The entries fetched during channel 31 are those of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-cell clock; every edge ends one bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_cnt | input | 5 | Current channel number from the timing generator |
| bit_cnt | input | 3 | Current bit cell within the channel, 0 = MSB cell |
| ode | input | 1 | Global output drive enable, active high |
| msg_all | input | 1 | Global message mode: every channel sends its low entry and is driven |
| cm_addr | output | 7 | Connection memory read address {stream, channel} |
| cm_hi_rd | input | 8 | Control entry returned one cycle after `cm_addr` |
| cm_lo_rd | input | 8 | Low entry returned one cycle after `cm_addr` |
| dm_addr | output | 7 | Data memory read address {stream, channel} |
| dm_rd | input | 8 | Data byte returned one cycle after `dm_addr` |
| st_out | output | 4 | Serial output bit, one per stream |
| st_oe | output | 4 | Drive enable for each stream's tri-state buffer |

## Verification
The bench uses four kinds of connection content. In the first, every channel is switched and enabled, with random source addresses that have bit 7 set at random. This separates address decoding from message passing. In the second, every channel is in message mode, which shows whether bit 7 reaches the line. The third has fully random control bytes. The fourth alternates the enable from one channel to the next, which exposes any enable that moves in the middle of a channel. On top of these, global message mode is applied over control bytes with both action bits cleared, so it is clear whether the override and not the stored bits is in control. The drive enable is also dropped in the middle of a channel to show that it acts within the cycle. Directed entries at addresses 0 and 127, a message held over two frames and then changed, and a check of the fetch addresses at the channel 31 to channel 0 wrap complete the set.

// File: rtl/tsi_out_pkg.sv
package tsi_out_pkg;
  // Frame geometry
  localparam int STREAMS = 4;
  localparam int CHANS   = 32;
  localparam int BYTE_W  = 8;

  // Derived widths
  localparam int STR_W  = $clog2(STREAMS);
  localparam int CH_W   = $clog2(CHANS);
  localparam int ADDR_W = STR_W + CH_W;
  localparam int BIT_W  = $clog2(BYTE_W);

  // Control entry bit positions
  localparam int HI_MSG_BIT   = 2;
  localparam int HI_SPARE_BIT = 1;
  localparam int HI_EN_BIT    = 0;

  // Bit cell that closes a channel
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
endpackage

// File: rtl/tsi_out_fetch.sv
module tsi_out_fetch
  import tsi_out_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CH_W-1:0]                   chan_cnt,
  input  logic [BIT_W-1:0]                  bit_cnt,
  output logic [ADDR_W-1:0]                 cm_addr,
  input  logic [BYTE_W-1:0]                 cm_hi_rd,
  input  logic [BYTE_W-1:0]                 cm_lo_rd,
  output logic [ADDR_W-1:0]                 dm_addr,
  input  logic [BYTE_W-1:0]                 dm_rd,
  output logic [STREAMS-1:0]                hi_msg,
  output logic [STREAMS-1:0]                hi_en,
  output logic [STREAMS-1:0][BYTE_W-1:0]    lo_byte,
  output logic [STREAMS-1:0][BYTE_W-1:0]    dm_byte
);

  logic [CH_W-1:0] next_chan;

  // Entries are fetched one channel ahead; last channel wraps to 0
  assign next_chan = (chan_cnt == CH_W'(CHANS - 1)) ? '0 : chan_cnt + 1'b1;

  // Slot b (< STREAMS) reads the connection entry of stream b
  assign cm_addr = {bit_cnt[STR_W-1:0], next_chan};

  // The low entry returned in slot b addresses the data memory directly
  assign dm_addr = cm_lo_rd[ADDR_W-1:0];

  // Spare control bits are read but never acted upon
  logic unused_hi_bits;
  assign unused_hi_bits = ^{cm_hi_rd[BYTE_W-1:HI_MSG_BIT+1], cm_hi_rd[HI_SPARE_BIT]};

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane_cap
    logic               msg_q;
    logic               en_q;
    logic [BYTE_W-1:0]  lo_q;
    logic [BYTE_W-1:0]  dat_q;
    logic               cap_cm;
    logic               cap_dm;

    assign cap_cm = (bit_cnt == BIT_W'(s + 1));
    assign cap_dm = (bit_cnt == BIT_W'(s + 2));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msg_q <= 1'b0;
        en_q  <= 1'b0;
        lo_q  <= '0;
      end else if (cap_cm) begin
        msg_q <= cm_hi_rd[HI_MSG_BIT];
        en_q  <= cm_hi_rd[HI_EN_BIT];
        lo_q  <= cm_lo_rd;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
      end else if (cap_dm) begin
        dat_q <= dm_rd;
      end
    end

    assign hi_msg[s]  = msg_q;
    assign hi_en[s]   = en_q;
    assign lo_byte[s] = lo_q;
    assign dm_byte[s] = dat_q;
  end

  // R11
  bit_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != '0) |-> (bit_cnt == $past(bit_cnt) + 1'b1));

  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != '0) |-> $stable(chan_cnt));

endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
  import tsi_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              msg_all,
  input  logic              hi_msg,
  input  logic              hi_en,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic [BYTE_W-1:0] dm_byte,
  output logic              ser_bit,
  output logic              drv_en
);

  logic [BYTE_W-1:0] sh_q;
  logic              en_q;
  logic              send_lo;

  assign send_lo = msg_all | hi_msg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      en_q <= 1'b0;
    end else if (load) begin
      sh_q <= send_lo ? lo_byte : dm_byte;
      en_q <= msg_all | hi_en;
    end else begin
      sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign ser_bit = sh_q[BYTE_W-1];
  assign drv_en  = en_q;

  // R3
  msg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (msg_all || hi_msg)) |=> (sh_q == $past(lo_byte)));

  // R2
  sw_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !msg_all && !hi_msg) |=> (sh_q == $past(dm_byte)));

  // R7
  chan_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !msg_all) |=> (drv_en == $past(hi_en)));

endmodule

// File: rtl/tsi_out_path.sv
module tsi_out_path
  import tsi_out_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CH_W-1:0]    chan_cnt,
  input  logic [BIT_W-1:0]   bit_cnt,
  input  logic               ode,
  input  logic               msg_all,
  output logic [ADDR_W-1:0]  cm_addr,
  input  logic [BYTE_W-1:0]  cm_hi_rd,
  input  logic [BYTE_W-1:0]  cm_lo_rd,
  output logic [ADDR_W-1:0]  dm_addr,
  input  logic [BYTE_W-1:0]  dm_rd,
  output logic [STREAMS-1:0] st_out,
  output logic [STREAMS-1:0] st_oe
);

  logic                           load;
  logic [STREAMS-1:0]             hi_msg;
  logic [STREAMS-1:0]             hi_en;
  logic [STREAMS-1:0][BYTE_W-1:0] lo_byte;
  logic [STREAMS-1:0][BYTE_W-1:0] dm_byte;
  logic [STREAMS-1:0]             lane_en;

  assign load = (bit_cnt == LAST_BIT);

  tsi_out_fetch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_cnt (chan_cnt),
    .bit_cnt  (bit_cnt),
    .cm_addr  (cm_addr),
    .cm_hi_rd (cm_hi_rd),
    .cm_lo_rd (cm_lo_rd),
    .dm_addr  (dm_addr),
    .dm_rd    (dm_rd),
    .hi_msg   (hi_msg),
    .hi_en    (hi_en),
    .lo_byte  (lo_byte),
    .dm_byte  (dm_byte)
  );

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    tsi_out_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .msg_all (msg_all),
      .hi_msg  (hi_msg[s]),
      .hi_en   (hi_en[s]),
      .lo_byte (lo_byte[s]),
      .dm_byte (dm_byte[s]),
      .ser_bit (st_out[s]),
      .drv_en  (lane_en[s])
    );
  end

  // Pin-level override acts within the cycle
  assign st_oe = lane_en & {STREAMS{ode}};

  // R10
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_cnt != '0) && $stable(ode)) |-> $stable(st_oe));

  // R5
  bcast_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && msg_all) |=> (!ode || (st_oe == '1)));

endmodule

// File: tb/test_tsi_out_path.sv
`timescale 1ns/1ps
module test_tsi_out_path;
  import tsi_out_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [CH_W-1:0]    chan_cnt = '0;
  logic [BIT_W-1:0]   bit_cnt = '0;
  logic               ode = 1'b1;
  logic               msg_all = 1'b0;
  logic [ADDR_W-1:0]  cm_addr;
  logic [BYTE_W-1:0]  cm_hi_rd = '0;
  logic [BYTE_W-1:0]  cm_lo_rd = '0;
  logic [ADDR_W-1:0]  dm_addr;
  logic [BYTE_W-1:0]  dm_rd = '0;
  logic [STREAMS-1:0] st_out;
  logic [STREAMS-1:0] st_oe;

  logic [7:0] hi_mem [0:127];
  logic [7:0] lo_mem [0:127];
  logic [7:0] dm_mem [0:127];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tsi_out_path i_tsi_out_path (
    .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt), .bit_cnt(bit_cnt),
    .ode(ode), .msg_all(msg_all), .cm_addr(cm_addr), .cm_hi_rd(cm_hi_rd),
    .cm_lo_rd(cm_lo_rd), .dm_addr(dm_addr), .dm_rd(dm_rd),
    .st_out(st_out), .st_oe(st_oe)
  );

  // Free-running timing generator
  initial begin
    forever begin
      @(posedge clk);
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == 3'd7) chan_cnt <= chan_cnt + 1'b1;
    end
  end

  // Synchronous-read memory models, one cycle latency
  initial begin
    forever begin
      @(posedge clk);
      cm_hi_rd <= hi_mem[cm_addr];
      cm_lo_rd <= lo_mem[cm_addr];
      dm_rd    <= dm_mem[dm_addr];
    end
  end

  task automatic chk_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at t=%0t chan=%0d bit=%0d: actual=%0h expected=%0h",
               req, $time, chan_cnt, bit_cnt, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int s, int c);
    logic [7:0] lo;
    lo = lo_mem[s*CHANS + c];
    if (msg_all || hi_mem[s*CHANS + c][2]) return lo;
    return dm_mem[lo[6:0]];
  endfunction

  function automatic logic exp_en(int s, int c);
    return ode && (msg_all || hi_mem[s*CHANS + c][0]);
  endfunction

  task automatic goto_frame_start();
    while (!(chan_cnt == '0 && bit_cnt == '0)) @(negedge clk);
  endtask

  // Called at a frame-start negedge; new content fully visible next frame
  task automatic settle();
    @(negedge clk);
    goto_frame_start();
  endtask

  task automatic check_frame(string dreq, string ereq);
    for (int i = 0; i < CHANS*8; i++) begin
      int c, k, nx;
      logic [7:0] eb;
      c  = int'(chan_cnt);
      k  = int'(bit_cnt);
      nx = (c == CHANS-1) ? 0 : c + 1;
      for (int s = 0; s < STREAMS; s++) begin
        eb = exp_byte(s, c);
        chk_eq(dreq, 32'(st_out[s]), 32'(eb[7-k]));
        chk_eq(ereq, 32'(st_oe[s]), 32'(exp_en(s, c)));
      end
      if (k < STREAMS)
        chk_eq((c == CHANS-1) ? "R12" : "R11", 32'(cm_addr), 32'(k*CHANS + nx));
      if (k >= 1 && k <= STREAMS)
        chk_eq("R11", 32'(dm_addr), 32'(lo_mem[(k-1)*CHANS + nx][6:0]));
      @(negedge clk);
    end
  endtask

  // mode 0 switched+enabled, 1 message, 2 random, 3 alternate enable, 4 action bits cleared
  task automatic fill(int mode);
    for (int a = 0; a < 128; a++) begin
      logic [7:0] h;
      h = 8'($urandom);
      case (mode)
        0: h = (h & 8'hFA) | 8'h01;
        1: h = h | 8'h04;
        3: h = (h & 8'hFE) | 8'((a[0] ^ a[5]) ? 1 : 0);
        4: h = h & 8'hFA;
        default: ;
      endcase
      hi_mem[a] = h;
      lo_mem[a] = 8'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 128; a++) begin
      hi_mem[a] = '0; lo_mem[a] = '0; dm_mem[a] = 8'($urandom);
    end

    // R1: outputs quiet in reset
    repeat (3) begin
      @(negedge clk);
      chk_eq("R1", 32'(st_oe), 32'h0);
      chk_eq("R1", 32'(st_out), 32'h0);
    end
    fill(0);
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    #1;
    while (bit_cnt != '0) begin
      chk_eq("R1", 32'(st_oe), 32'h0);
      chk_eq("R1", 32'(st_out), 32'h0);
      @(negedge clk);
    end

    // R2 / R9: switched, directed corners at addresses 0 and 127
    goto_frame_start();
    fill(0);
    lo_mem[0]   = 8'hFF; dm_mem[127] = 8'hA5;
    lo_mem[127] = 8'h80; dm_mem[0]   = 8'h3C;
    settle();
    check_frame("R2", "R7");
    check_frame("R9", "R7");

    // R3 / R4: message channels, repeated, then changed
    fill(1);
    settle();
    check_frame("R3", "R7");
    check_frame("R4", "R7");
    for (int a = 0; a < 128; a++) lo_mem[a] = 8'($urandom);
    settle();
    check_frame("R4", "R7");

    // R8: fully random control bytes
    fill(2);
    settle();
    check_frame("R8", "R8");

    // R10: enable alternates channel to channel
    fill(3);
    settle();
    check_frame("R2", "R10");

    // R5: global message mode over cleared action bits
    fill(4);
    msg_all = 1'b1;
    settle();
    check_frame("R5", "R5");

    // R6: global drive enable low
    ode = 1'b0;
    settle();
    check_frame("R5", "R6");

    // R6: mid-channel drop takes effect in the same cycle
    ode = 1'b1;
    settle();
    while (bit_cnt != 3'd3) @(negedge clk);
    chk_eq("R6", 32'(st_oe), 32'hF);
    ode = 1'b0;
    #1;
    chk_eq("R6", 32'(st_oe), 32'h0);
    ode = 1'b1;
    #1;
    chk_eq("R6", 32'(st_oe), 32'hF);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule